// File: doc/BRIEF.md
# Auxiliary Video Information InfoFrame Packer

This block assembles the thirteen-byte payload of an auxiliary video information InfoFrame for a selected video identification code (VIC). It then folds the sink's overscan and underscan capability into the first payload byte and computes the frame checksum. The result comes out as four 32-bit words that a packet engine can copy straight into its InfoFrame buffer.

A controller raises a one-cycle start pulse with the chosen VIC, the scan capability fields read from the sink and a flag that says whether the chosen format is the sink's preferred one. One cycle later the packed words are valid and a single-cycle update strobe marks them. A VIC with no table entry leaves the outputs unchanged and raises no strobe.

Top module: `avi_frame_packer`

## Requirements
- R1: The payload table holds three modes. Payload byte 1 comes first in each list below, and byte 4 equals the VIC.
  - VIC 1: 10 18 00 01 00 00 00 E1 01 00 00 81 02
  - VIC 4: 10 28 00 04 00 00 00 D1 02 00 00 01 05
  - VIC 16: 10 28 00 10 00 00 00 39 04 00 00 81 07
- R2: The checksum is (256 − ((0x82 + 0x02 + 13 + sum of the 13 payload bytes) mod 256)) mod 256. With it, all header and payload bytes plus the checksum add up to 0 mod 256.
- R3: In word 0, bits 7:0 hold the checksum, bits 15:8 hold payload byte 1, bits 23:16 hold byte 2 and bits 31:24 hold byte 3.
- R4: Word 1 holds payload bytes 4, 5, 6 and 7, and word 2 holds bytes 8, 9, 10 and 11. In both words the lowest-numbered byte sits in bits 7:0 and the others follow upward.
- R5: Word 3 holds payload byte 12 in bits 7:0, byte 13 in bits 15:8, zero in bits 23:16 and the value 0x02 in bits 31:24.
- R6: The two scan bits are ORed into bits 1:0 of payload byte 1 before the checksum is formed. Bit 0 of the scan value is never set.
- R7: When the format is the preferred one, the 2-bit preferred-scan field decides the scan bits. A value of 3 sets scan bit 1. A value of 0 defers to the CE field. A value of 1 or 2 gives zero scan bits, whatever the CE field holds.
- R8: When the CE field is consulted (non-preferred format, or preferred-scan field equal to 0) and that field equals 3, scan bit 1 is set. Any other value gives zero scan bits.
- R9: A start with a VIC outside the table raises no update strobe, and all four words keep their previous values.
- R10: After reset all words are zero and the strobe is low. For a start with a listed VIC, the words and a one-cycle strobe appear in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to build a frame |
| vic_i | input | VIC_W | Selected video identification code |
| fmt_is_pref_i | input | 1 | Selected format is the sink's preferred format |
| pref_scan_i | input | 2 | Sink scan capability for the preferred format |
| ce_scan_i | input | 2 | Sink scan capability for consumer-electronics formats |
| word0_o | output | 32 | Checksum and payload bytes 1 to 3 |
| word1_o | output | 32 | Payload bytes 4 to 7 |
| word2_o | output | 32 | Payload bytes 8 to 11 |
| word3_o | output | 32 | Payload bytes 12, 13 and version |
| update_o | output | 1 | Words were refreshed this cycle |

## Verification
The assertions assume that the VIC and the scan fields are steady around the clock edge where start is sampled, and that the scan fields carry only the four 2-bit codes. The bench changes every input on the falling edge, one full half-period before it is sampled. It then sweeps all 128 VIC values against every combination of the preferred flag and both scan fields. Between starts it holds an idle cycle, so the strobe width and the hold of the words can be observed.

// File: rtl/avi_pack_pkg.sv
package avi_pack_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned DB_COUNT = 13;
   localparam int unsigned WORD_W   = 4 * BYTE_W;
   localparam int unsigned N_WORDS  = 4;

   localparam logic [BYTE_W-1:0] HDR_TYPE = 8'h82;
   localparam logic [BYTE_W-1:0] HDR_VER  = 8'h02;
   localparam logic [BYTE_W-1:0] HDR_LEN  = BYTE_W'(DB_COUNT);

   typedef logic [BYTE_W-1:0]                byte_t;
   typedef byte_t [DB_COUNT-1:0]             payload_t;   // index 0 = payload byte 1
   typedef logic [N_WORDS-1:0][WORD_W-1:0]   words_t;

   typedef enum logic [1:0] {
      CAP_NONE  = 2'd0,
      CAP_OVER  = 2'd1,
      CAP_UNDER = 2'd2,
      CAP_BOTH  = 2'd3
   } scan_cap_e;

   // Sum of header constants and every byte lane carried by the packed words
   function automatic byte_t frame_sum(input words_t w);
      byte_t acc;
      acc = HDR_TYPE + HDR_VER + HDR_LEN;
      for (int k = 0; k < 3; k++)
         for (int b = 0; b < 4; b++)
            acc = acc + w[k][b*BYTE_W +: BYTE_W];
      acc = acc + w[3][7:0] + w[3][15:8];
      return acc;
   endfunction
endpackage

// File: rtl/avi_mode_rom.sv
module avi_mode_rom
   import avi_pack_pkg::*;
#(
   parameter int unsigned VIC_W = 7
)(
   input  logic [VIC_W-1:0] vic_i,
   output logic             hit_o,
   output payload_t         payload_o
);
   always_comb begin
      hit_o     = 1'b1;
      payload_o = '0;
      case (vic_i)
         VIC_W'(1):  payload_o = {8'h02, 8'h81, 8'h00, 8'h00, 8'h01, 8'hE1, 8'h00,
                                  8'h00, 8'h00, 8'h01, 8'h00, 8'h18, 8'h10};
         VIC_W'(4):  payload_o = {8'h05, 8'h01, 8'h00, 8'h00, 8'h02, 8'hD1, 8'h00,
                                  8'h00, 8'h00, 8'h04, 8'h00, 8'h28, 8'h10};
         VIC_W'(16): payload_o = {8'h07, 8'h81, 8'h00, 8'h00, 8'h04, 8'h39, 8'h00,
                                  8'h00, 8'h00, 8'h10, 8'h00, 8'h28, 8'h10};
         default:    hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/avi_scan_select.sv
module avi_scan_select
   import avi_pack_pkg::*;
(
   input  logic       is_pref_i,
   input  scan_cap_e  pref_cap_i,
   input  scan_cap_e  ce_cap_i,
   output logic [1:0] scan_o
);
   logic use_ce;

   always_comb begin
      scan_o = 2'b00;
      use_ce = 1'b1;
      if (is_pref_i) begin
         use_ce = 1'b0;
         case (pref_cap_i)
            CAP_NONE: use_ce = 1'b1;
            CAP_BOTH: scan_o = 2'b10;
            default:  ;
         endcase
      end
      if (use_ce && (ce_cap_i == CAP_BOTH))
         scan_o = scan_o | 2'b10;
   end
endmodule

// File: rtl/avi_word_pack.sv
module avi_word_pack
   import avi_pack_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  payload_t   payload_i,
   input  logic [1:0] scan_i,
   output words_t     words_o,
   output logic       update_o
);
   payload_t db;
   byte_t    body_sum;
   byte_t    cks;
   words_t   words_d;
   words_t   words_q;
   logic     upd_q;

   always_comb begin
      db       = payload_i;
      db[0]    = payload_i[0] | {6'b0, scan_i};
      body_sum = HDR_TYPE + HDR_VER + HDR_LEN;
      for (int i = 0; i < DB_COUNT; i++)
         body_sum = body_sum + db[i];
      cks = 8'd0 - body_sum;
   end

   assign words_d[0] = {db[2], db[1], db[0], cks};
   for (genvar g = 1; g <= 2; g++) begin : g_mid
      assign words_d[g] = {db[4*g+2], db[4*g+1], db[4*g], db[4*g-1]};
   end
   assign words_d[3] = {HDR_VER, 8'h00, db[12], db[11]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words_q <= '0;
         upd_q   <= 1'b0;
      end else begin
         upd_q <= load_i;
         if (load_i)
            words_q <= words_d;
      end
   end

   assign words_o  = words_q;
   assign update_o = upd_q;

   p_cksum_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> (frame_sum(words_q) == 8'h00));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(words_q));
   p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> $past(load_i));
   p_w3_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> (words_q[3][31:16] == {HDR_VER, 8'h00}));
endmodule

// File: rtl/avi_frame_packer.sv
module avi_frame_packer
   import avi_pack_pkg::*;
#(
   parameter int unsigned VIC_W = 7
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VIC_W-1:0] vic_i,
   input  logic             fmt_is_pref_i,
   input  logic [1:0]       pref_scan_i,
   input  logic [1:0]       ce_scan_i,
   output logic [31:0]      word0_o,
   output logic [31:0]      word1_o,
   output logic [31:0]      word2_o,
   output logic [31:0]      word3_o,
   output logic             update_o
);
   if (VIC_W < 5 || VIC_W > 8) begin : g_bad_vic_w
      $error("VIC_W must be between 5 and 8");
   end
   if (WORD_W != 32) begin : g_bad_word_w
      $error("packed word width must be 32");
   end

   logic       hit;
   payload_t   payload;
   logic [1:0] scan;
   words_t     words;
   logic       load;

   avi_mode_rom #(.VIC_W(VIC_W)) u_rom (
      .vic_i     (vic_i),
      .hit_o     (hit),
      .payload_o (payload)
   );

   avi_scan_select u_scan (
      .is_pref_i  (fmt_is_pref_i),
      .pref_cap_i (scan_cap_e'(pref_scan_i)),
      .ce_cap_i   (scan_cap_e'(ce_scan_i)),
      .scan_o     (scan)
   );

   assign load = start_i & hit;

   avi_word_pack u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .payload_i(payload),
      .scan_i   (scan),
      .words_o  (words),
      .update_o (update_o)
   );

   assign word0_o = words[0];
   assign word1_o = words[1];
   assign word2_o = words[2];
   assign word3_o = words[3];

   p_rom_vic_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (payload[3] == 8'(vic_i)));
   p_scan_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scan[0] == 1'b0);
   p_pref_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_is_pref_i && pref_scan_i == 2'd3) |-> (scan == 2'b10));
   p_pref_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_is_pref_i && (pref_scan_i == 2'd1 || pref_scan_i == 2'd2)) |-> (scan == 2'b00));
   p_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fmt_is_pref_i) |-> (scan == ((ce_scan_i == 2'd3) ? 2'b10 : 2'b00)));
   p_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !hit) |=> !update_o);
endmodule

// File: tb/avi_frame_packer_test.sv
`timescale 1ns/1ps
module avi_frame_packer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [6:0]  vic_i = '0;
   logic        fmt_is_pref_i = 1'b0;
   logic [1:0]  pref_scan_i = '0;
   logic [1:0]  ce_scan_i = '0;
   logic [31:0] word0_o, word1_o, word2_o, word3_o;
   logic        update_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2.5 clk = ~clk;

   avi_frame_packer #(.VIC_W(7)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vic_i(vic_i),
      .fmt_is_pref_i(fmt_is_pref_i), .pref_scan_i(pref_scan_i), .ce_scan_i(ce_scan_i),
      .word0_o(word0_o), .word1_o(word1_o), .word2_o(word2_o), .word3_o(word3_o),
      .update_o(update_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, act, exp);
      end
   endtask

   // R1: expected payload bytes, index 1..13
   function automatic logic [7:0] tbl(input int v, input int i);
      logic [7:0] a1 [13] = '{8'h10,8'h18,8'h00,8'h01,8'h00,8'h00,8'h00,8'hE1,8'h01,8'h00,8'h00,8'h81,8'h02};
      logic [7:0] a4 [13] = '{8'h10,8'h28,8'h00,8'h04,8'h00,8'h00,8'h00,8'hD1,8'h02,8'h00,8'h00,8'h01,8'h05};
      logic [7:0] a16[13] = '{8'h10,8'h28,8'h00,8'h10,8'h00,8'h00,8'h00,8'h39,8'h04,8'h00,8'h00,8'h81,8'h07};
      if (v == 1) return a1[i-1];
      if (v == 4) return a4[i-1];
      return a16[i-1];
   endfunction

   // R7 / R8 expected scan bits
   function automatic logic [1:0] exp_scan(input bit pref, input int ps, input int cs);
      if (pref && ps == 3) return 2'b10;
      if (pref && ps != 0) return 2'b00;
      return (cs == 3) ? 2'b10 : 2'b00;
   endfunction

   initial begin
      logic [31:0] hold0, hold1, hold2, hold3;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 reset word0", word0_o, 32'h0);
      check("R10 reset word3", word3_o, 32'h0);
      check("R10 reset strobe", {31'b0, update_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int v = 0; v < 128; v++) begin
         for (int p = 0; p < 2; p++) begin
            for (int ps = 0; ps < 4; ps++) begin
               for (int cs = 0; cs < 4; cs++) begin
                  bit hit;
                  logic [7:0] db [14];
                  logic [7:0] sum;
                  logic [7:0] ck;
                  hit = (v == 1) || (v == 4) || (v == 16);
                  hold0 = word0_o; hold1 = word1_o; hold2 = word2_o; hold3 = word3_o;
                  vic_i = 7'(v); fmt_is_pref_i = p[0];
                  pref_scan_i = 2'(ps); ce_scan_i = 2'(cs);
                  start_i = 1'b1;
                  @(posedge clk);
                  @(negedge clk);
                  start_i = 1'b0;
                  if (hit) begin
                     for (int i = 1; i <= 13; i++) db[i] = tbl(v, i);
                     db[1] = db[1] | {6'b0, exp_scan(p[0], ps, cs)};   // R6
                     sum = 8'h82 + 8'h02 + 8'd13;
                     for (int i = 1; i <= 13; i++) sum = sum + db[i];
                     ck = 8'((256 - int'(sum)) % 256);                   // R2
                     check("R10 strobe after start", {31'b0, update_o}, 32'h1);
                     check("R3/R2/R6/R7/R8 word0", word0_o, {db[3], db[2], db[1], ck});
                     check("R4/R1 word1", word1_o, {db[7], db[6], db[5], db[4]});
                     check("R4/R1 word2", word2_o, {db[11], db[10], db[9], db[8]});
                     check("R5/R1 word3", word3_o, {8'h02, 8'h00, db[13], db[12]});
                     hold0 = word0_o; hold1 = word1_o; hold2 = word2_o; hold3 = word3_o;
                  end else begin
                     check("R9 no strobe", {31'b0, update_o}, 32'h0);
                     check("R9 word0 held", word0_o, hold0);
                     check("R9 word3 held", word3_o, hold3);
                  end
                  @(posedge clk);
                  @(negedge clk);
                  // R10: single-cycle strobe, words held while idle
                  check("R10 strobe one cycle", {31'b0, update_o}, 32'h0);
                  check("R9 idle word1 held", word1_o, hold1);
                  check("R9 idle word2 held", word2_o, hold2);
               end
            end
         end
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule